// File: doc/BRIEF.md
# Programmable Down-Counting Interrupt Timer

This block is a register-programmed timer built around a wide down counter. Software writes a start value into the reload register, and the counter then decrements once per scaled clock period. When the count steps from one to zero the block emits an interrupt pulse. In repeating mode it then refills itself from the reload register and keeps going. In single-shot mode it parks at zero until it is written again.

A prescaler sets the decrement rate, dividing the bus clock by 1, 2, 4, 8, 16, 32, 64 or 128. A 4-bit divider code selects the ratio. Writing a zero start value halts the timer at once.

Software reaches the block through a simple single-cycle register port. A write is taken on the clock edge where select and write are both high. Read data is combinational from the address while select is high. The port always completes in one cycle and never back-pressures. The interrupt output is a plain pulse line.

Top module: `cdt_timer`

## Requirements
- R1: After reset every register reads zero (mode word, reload value, live count, divider code), the timer is idle and the interrupt output is low.
- R2: Registers are selected by address bits [3:2]:
  - 0 is the mode word, where bit 17 = repeat and bit 16 = mask; all other bits read zero.
  - 1 is the reload value, which reads back what was last written.
  - 2 is the live count; it is read-only and writes to it are ignored.
  - 3 is the divider code; it keeps bits [3:0] and reads zero above them.
  - With select low, read data is zero.
- R3: The divider code uses bits {3,1,0}, and bit 2 is ignored. The eight codes map as follows:
  - 0x0 divides by 2, 0x1 by 4, 0x2 by 8, 0x3 by 16.
  - 0x8 divides by 32, 0x9 by 64, 0xA by 128.
  - 0xB divides by 1.
  - With ratio N, the count drops by one every N clock edges.
- R4: Writing the divider code restarts the prescaler phase. No decrement happens on the writing edge, and the next one comes N edges after it.
- R5: Writing a nonzero reload value loads it into the live count on that same edge and restarts the prescaler, even in the middle of a count.
- R6: In repeat mode, the step from one to zero instead reloads the count from the reload value. Expiries therefore repeat every value×N edges.
- R7: In single-shot mode the count stops at zero after its expiry, with no wrap-around and no further pulses.
- R8: Writing zero to the reload value clears the live count, and no interrupt pulse follows.
- R9: While the mask bit is set the interrupt output stays low, but counting and reloading go on unchanged.
- R10: Each expiry gives a one-cycle interrupt pulse in the cycle after the edge where the count left the value one. Back-to-back expiries give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_pulse | output | 1 | One-cycle expiry pulse |

## Verification
The hardest cases are register writes that land on the very edge where the prescaler would have stepped the counter. Two such writes matter:
- a divider change in the middle of a slow count;
- a reload rewrite while the count is about to expire.

The bench drives these writes on cycles picked by a behavioural model that tracks the remaining edges to each decrement. A reload of one at divide-by-one in repeat mode makes the pulse train fire on every cycle, which exposes any logic that assumes pulses are isolated.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int DIV_CODE_W   = 4;
  localparam int SHIFT_W      = 3;
  localparam int PSC_W        = (1 << SHIFT_W) - 1;
  localparam int PERIODIC_BIT = 17;
  localparam int MASK_BIT     = 16;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_LOAD  = 2'd1,
    REG_LIVE  = 2'd2,
    REG_DIV   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic repeat_en;
    logic mask;
  } mode_t;

  // Power-of-two exponent of the divide ratio: bits {3,1,0} plus one, modulo 8.
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_CODE_W-1:0] code);
    logic [SHIFT_W-1:0] v;
    v = {code[3], code[1], code[0]};
    return v + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               run,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PSC_W-1:0] phase;
  logic [PSC_W-1:0] limit;

  always_comb begin
    for (int i = 0; i < PSC_W; i++) begin
      limit[i] = (SHIFT_W'(i) < shift);
    end
  end

  assign tick = run && !clear && (phase == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (clear || !run) begin
      phase <= '0;
    end else if (phase == limit) begin
      phase <= '0;
    end else begin
      phase <= phase + PSC_W'(1);
    end
  end

  // R3: the phase never passes the selected ratio
  p_phase_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= limit);
endmodule

// File: rtl/cdt_downcount.sv
module cdt_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             repeat_en,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (tick) begin
      if (count == ONE) begin
        count <= repeat_en ? reload_val : '0;
      end else begin
        count <= count - ONE;
      end
    end
  end

  // R5: a write of the reload value lands in the count on that edge
  p_load_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));

  // R7: once idle at zero the count stays there until reloaded
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load) |=> count == '0);

  // R6: without a load the count only holds, steps by one, or refills
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count == $past(count) || count == $past(count) - ONE ||
               count == $past(reload_val)));
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W-1:0]     live_count,
  output logic [DATA_W-1:0]     rdata,
  output mode_t                 mode,
  output logic [DATA_W-1:0]     reload_val,
  output logic [DIV_CODE_W-1:0] div_code,
  output logic                  load_wr,
  output logic                  div_wr
);
  reg_sel_e idx;
  logic     wr_en;
  logic     mode_wr;

  assign idx     = reg_sel_e'(addr[3:2]);
  assign wr_en   = sel && wr;
  assign mode_wr = wr_en && (idx == REG_MODE);
  assign load_wr = wr_en && (idx == REG_LOAD);
  assign div_wr  = wr_en && (idx == REG_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= '0;
      reload_val <= '0;
      div_code   <= '0;
    end else begin
      if (mode_wr) begin
        mode.repeat_en <= wdata[PERIODIC_BIT];
        mode.mask      <= wdata[MASK_BIT];
      end
      if (load_wr) reload_val <= wdata;
      if (div_wr)  div_code   <= wdata[DIV_CODE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      unique case (idx)
        REG_MODE: begin
          rdata[PERIODIC_BIT] = mode.repeat_en;
          rdata[MASK_BIT]     = mode.mask;
        end
        REG_LOAD: rdata = reload_val;
        REG_LIVE: rdata = live_count;
        REG_DIV:  rdata[DIV_CODE_W-1:0] = div_code;
        default:  rdata = '0;
      endcase
    end
  end

  // R2: the divider code only changes through its own write
  p_div_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !div_wr |=> $stable(div_code));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_pulse
);
  mode_t                 mode;
  logic [CNT_W-1:0]      reload_val;
  logic [CNT_W-1:0]      count;
  logic [DIV_CODE_W-1:0] div_code;
  logic                  load_wr;
  logic                  div_wr;
  logic                  tick;
  logic                  expire;
  logic                  run;

  assign run = (count != '0);

  cdt_regs #(.DATA_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (bus_sel),
    .wr         (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .live_count (count),
    .rdata      (bus_rdata),
    .mode       (mode),
    .reload_val (reload_val),
    .div_code   (div_code),
    .load_wr    (load_wr),
    .div_wr     (div_wr)
  );

  cdt_prescaler u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load_wr || div_wr),
    .run   (run),
    .shift (div_shift(div_code)),
    .tick  (tick)
  );

  cdt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_wr),
    .load_val   (bus_wdata),
    .tick       (tick),
    .repeat_en  (mode.repeat_en),
    .reload_val (reload_val),
    .count      (count),
    .expire     (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= expire && !mode.mask;
  end

  // R8: an idle counter cannot raise a pulse
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> !irq_pulse);

  // R9: a set mask keeps the output low
  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode.mask |=> !irq_pulse);

  // R10: every pulse is caused by the count leaving one
  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(count) == CNT_W'(1));
endmodule

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #5 clk = ~clk;

  cdt_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_pulse(irq)
  );

  int    vectors = 0, errs = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural reference
  logic [31:0] m_cnt = 0, m_init = 0;
  int          m_div = 0, m_wait = 0;
  bit          m_per = 0, m_mask = 0, m_irq = 0;

  function automatic int ratio_of(int code);
    case ({code[3], code[1], code[0]})
      3'd0: return 2;   3'd1: return 4;   3'd2: return 8;   3'd3: return 16;
      3'd4: return 32;  3'd5: return 64;  3'd6: return 128; default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (!sel) return 0;
    case (addr[3:2])
      2'd0: return (32'(m_per) << 17) | (32'(m_mask) << 16);
      2'd1: return m_init;
      2'd2: return m_cnt;
      default: return 32'(m_div);
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    bit ev = 0;
    bit pm = m_per, mk = m_mask;
    bit wen = sel && wr;
    if (wen && addr[3:2] == 2'd1) begin
      m_init = wdata; m_cnt = wdata; m_wait = ratio_of(m_div);
    end else if (wen && addr[3:2] == 2'd3) begin
      m_div = int'(wdata[3:0]); m_wait = ratio_of(m_div);
    end else if (m_cnt != 0) begin
      m_wait--;
      if (m_wait == 0) begin
        m_wait = ratio_of(m_div);
        if (m_cnt == 1) begin ev = 1; m_cnt = pm ? m_init : 0; end
        else m_cnt = m_cnt - 1;
      end
    end
    if (wen && addr[3:2] == 2'd0) begin m_per = wdata[17]; m_mask = wdata[16]; end
    m_irq = ev && !mk;
  endtask

  task automatic step(bit s, bit w, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    chk("irq", {31'b0, irq}, {31'b0, m_irq});
    chk("rdata", rdata, exp_rdata());
    sel = s; wr = w; addr = a; wdata = d;
    @(posedge clk);
    model();
  endtask

  task automatic put(logic [3:0] a, logic [31:0] d);
    step(1, 1, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 0, 4'h8, 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      errs++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values of every register
    tag = "R1";
    step(1, 0, 4'h0, 0); step(1, 0, 4'h4, 0); step(1, 0, 4'h8, 0); step(1, 0, 4'hC, 0);
    step(0, 0, 4'h4, 0);
    // R2: register map, masking and read-only live count
    tag = "R2";
    put(4'h0, 32'hFFFF_FFFF); step(1, 0, 4'h0, 0);
    put(4'h0, 32'h0);
    put(4'hC, 32'hFFFF_FFF7); step(1, 0, 4'hC, 0);
    put(4'h8, 32'h1234_5678); step(1, 0, 4'h8, 0);
    step(0, 0, 4'h0, 0);
    // R3 / R7: each divide code in single-shot mode
    for (int k = 0; k < 8; k++) begin
      int code = (k < 4) ? k : k + 4;
      tag = "R3";
      put(4'hC, 32'(code));
      put(4'h4, 32'd2);
      idle(2 * ratio_of(code) + 2);
      tag = "R7";
      idle(4);
    end
    put(4'hC, 32'h4);                  // bit 2 ignored: behaves as /2
    tag = "R3"; put(4'h4, 32'd3); idle(10);
    // R6: repeat mode at /2
    tag = "R6";
    put(4'h0, 32'h0002_0000);
    put(4'hC, 32'h0);
    put(4'h4, 32'd3); idle(30);
    // R10: back-to-back pulses at /1 with a reload of one
    tag = "R10";
    put(4'hC, 32'hB);
    put(4'h4, 32'd1); idle(8);
    put(4'h4, 32'd2); idle(9);
    // R5: rewrite mid count, including just before expiry
    tag = "R5";
    put(4'hC, 32'h1);
    put(4'h4, 32'd5); idle(7);
    put(4'h4, 32'd9); idle(13);
    put(4'h4, 32'd6); idle(22);
    // R4: divider change in the middle of a slow count
    tag = "R4";
    put(4'hC, 32'h3);
    put(4'h4, 32'd4); idle(21);
    put(4'hC, 32'h3); idle(17);
    put(4'hC, 32'h0); idle(9);
    put(4'hC, 32'h9); idle(140);
    // R9: masked output, counting continues
    tag = "R9";
    put(4'hC, 32'hB);
    put(4'h0, 32'h0003_0000);
    put(4'h4, 32'd3); idle(12);
    put(4'h0, 32'h0002_0000); idle(8);
    // R8: zero reload halts the timer
    tag = "R8";
    put(4'h4, 32'd0); idle(20);
    put(4'h0, 32'h0); idle(5);
    @(negedge clk);
    chk("irq", {31'b0, irq}, {31'b0, m_irq});
    chk("rdata", rdata, exp_rdata());
    done = 1;
    summary();
    $finish;
  end
endmodule